// File: doc/BRIEF.md
# Flash Self-Programming Command Register

This block is the control and status register through which software starts self-programming of on-chip program memory. A bus write that sets one command bit together with the enable bit arms that command for a few cycles. A store strobe from the CPU inside that window starts a page erase or a page write through the flash-controller handshake. A load strobe inside a shorter window is redirected to the lock or fuse bytes. A buffer-clear command sends a single pulse to the temporary page buffer.

While an erase or write is running, the block holds the CPU in halt and ignores register writes. When the flash controller reports completion, the command bit and the enable bit clear themselves. They also clear when the window expires unused, so an arm that has gone stale cannot start a later operation. A ready interrupt is raised when software has enabled it and no programming or EEPROM write is pending.

Top module: `flash_selfprog_ctl`

## Requirements
- R1: After reset every register bit reads 0, `fl_req_o`, `cpu_halt_o`, `buf_clr_o`, `lock_rd_o` and `rdy_irq_o` are low.
- R2: Readback places interrupt enable at bit 7, buffer clear at bit 4, lock-bit set at bit 3, page write at bit 2, page erase at bit 1 and the enable bit at bit 0. Bits 6 and 5 always read 0, even when written 1.
- R3: After a write of bits 2 and 0, a store strobe in any of the SPM_WIN cycles after the write cycle raises `fl_req_o` in the next cycle with `fl_op_o`=1 (write).
- R4: After a write of bits 1 and 0, a store strobe in any of the SPM_WIN cycles after the write cycle raises `fl_req_o` in the next cycle with `fl_op_o`=0 (erase).
- R5: `fl_page_o` carries the `zpage_i` value sampled with the accepted store strobe and holds it for the whole operation.
- R6: The command bit and the enable bit clear in the cycle after `fl_done_i`. If no strobe arrives within the window, they clear after SPM_WIN cycles, and a later strobe starts nothing.
- R7: `cpu_halt_o` is high from the cycle after the accepted strobe through the cycle of `fl_done_i`. Register writes in that interval are ignored.
- R8: After a write of bits 3 and 0, a load strobe in any of the LPM_WIN cycles after the write raises `lock_rd_o` in the same cycle, with `fuse_sel_o` equal to `zsel_i`. The arm then clears. A load strobe after the window leaves `lock_rd_o` low.
- R9: A write of bits 4 and 0 produces a one-cycle `buf_clr_o` pulse in the cycle after the write, after which the register reads 0.
- R10: `rdy_irq_o` is high only while interrupt enable is 1, `gie_i` is 1, the enable bit is 0, no operation is running and `ee_busy_i` is 0.
- R11: When a write sets more than one command bit with bit 0, only the winner is armed. The order from highest is erase, write, lock-bit set, buffer clear.
- R12: A write with bit 0 clear discards every command bit and stores only interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register readback |
| spm_strobe_i | input | 1 | Store-program-memory strobe from CPU |
| lpm_strobe_i | input | 1 | Load-program-memory strobe from CPU |
| zpage_i | input | PG_W | Page field of the Z-pointer |
| zsel_i | input | 1 | Z-pointer bit 0, selects fuse (1) or lock (0) byte |
| gie_i | input | 1 | Global interrupt flag |
| ee_busy_i | input | 1 | EEPROM write in progress |
| fl_req_o | output | 1 | Operation request to flash controller |
| fl_op_o | output | 1 | Operation kind: 1 write, 0 erase |
| fl_page_o | output | PG_W | Page address of the operation |
| fl_done_i | input | 1 | Completion pulse from flash controller |
| cpu_halt_o | output | 1 | CPU halt request |
| buf_clr_o | output | 1 | Page buffer clear pulse |
| lock_rd_o | output | 1 | Redirect current load to lock/fuse bytes |
| fuse_sel_o | output | 1 | Selects fuse byte during redirected load |
| rdy_irq_o | output | 1 | Ready interrupt request |

## Verification
The bench uses the default parameters: SPM_WIN=4, LPM_WIN=3 and a 9-bit page field. Both windows are short enough that every accepted offset can be swept, along with the first rejected one. The nine-bit page lets distinct page values confirm that the captured address stays put while `zpage_i` changes during an operation. A modelled flash controller answers after a fixed latency, so the halt interval and the ignored-write interval are several cycles long.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_ERASE = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_LOCK  = 3'd3,
    CMD_BCLR  = 3'd4
  } cmd_t;

  localparam int B_EN   = 0;
  localparam int B_ERS  = 1;
  localparam int B_WR   = 2;
  localparam int B_LCK  = 3;
  localparam int B_BCLR = 4;
  localparam int B_IEN  = 7;
endpackage

// File: rtl/fsp_cmd_decode.sv
module fsp_cmd_decode
  import fsp_pkg::*;
(
  input  logic [4:0] wbits_i,
  output cmd_t       cmd_o
);
  // fixed priority: erase > write > lock > buffer clear
  always_comb begin
    cmd_o = CMD_NONE;
    if (wbits_i[B_EN]) begin
      if (wbits_i[B_ERS])       cmd_o = CMD_ERASE;
      else if (wbits_i[B_WR])   cmd_o = CMD_WRITE;
      else if (wbits_i[B_LCK])  cmd_o = CMD_LOCK;
      else if (wbits_i[B_BCLR]) cmd_o = CMD_BCLR;
    end
  end
endmodule

// File: rtl/fsp_window.sv
module fsp_window #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          clear_i,
  output logic          active_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= len_i;
    else if (clear_i)          cnt_q <= '0;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
  assign expire_o = (cnt_q == CW'(1));

  AST_WIN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_o) else $error("window not loaded"); // R6
endmodule

// File: rtl/fsp_flash_seq.sv
module fsp_flash_seq #(
  parameter int PG_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            op_wr_i,
  input  logic [PG_W-1:0] page_i,
  input  logic            done_i,
  output logic            busy_o,
  output logic            op_wr_o,
  output logic [PG_W-1:0] page_o,
  output logic            fin_o
);
  logic            busy_q;
  logic            op_q;
  logic [PG_W-1:0] page_q;

  assign fin_o = busy_q & done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= 1'b0;
      page_q <= '0;
    end else if (fin_o) begin
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      op_q   <= op_wr_i;
      page_q <= page_i;
    end
  end

  assign busy_o  = busy_q;
  assign op_wr_o = op_q;
  assign page_o  = page_q;

  AST_PAGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(page_q) && $stable(op_q))) else $error("page moved"); // R5
endmodule

// File: rtl/flash_selfprog_ctl.sv
module flash_selfprog_ctl
  import fsp_pkg::*;
#(
  parameter int PG_W    = 9,
  parameter int SPM_WIN = 4,
  parameter int LPM_WIN = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  input  logic            spm_strobe_i,
  input  logic            lpm_strobe_i,
  input  logic [PG_W-1:0] zpage_i,
  input  logic            zsel_i,
  input  logic            gie_i,
  input  logic            ee_busy_i,
  output logic            fl_req_o,
  output logic            fl_op_o,
  output logic [PG_W-1:0] fl_page_o,
  input  logic            fl_done_i,
  output logic            cpu_halt_o,
  output logic            buf_clr_o,
  output logic            lock_rd_o,
  output logic            fuse_sel_o,
  output logic            rdy_irq_o
);
  localparam int WMAX = (SPM_WIN > LPM_WIN) ? SPM_WIN : LPM_WIN;
  localparam int CW   = $clog2(WMAX + 1);

  logic    ien_q, en_q;
  cmd_t    cmd_q, wr_cmd;
  logic    busy, seq_fin, win_active, win_expire;
  logic    wr_ok, spm_take, lpm_take, win_load, win_clear;
  logic [CW-1:0] win_len;
  logic    unused_wbits;

  assign unused_wbits = ^reg_wdata_i[6:5];

  fsp_cmd_decode u_dec (
    .wbits_i (reg_wdata_i[4:0]),
    .cmd_o   (wr_cmd)
  );

  assign wr_ok    = reg_we_i & ~busy;
  assign spm_take = en_q & ~busy & ~reg_we_i & spm_strobe_i &
                    ((cmd_q == CMD_ERASE) | (cmd_q == CMD_WRITE));
  assign lpm_take = en_q & ~reg_we_i & lpm_strobe_i & (cmd_q == CMD_LOCK);

  always_comb begin
    case (wr_cmd)
      CMD_LOCK: win_len = CW'(LPM_WIN);
      CMD_BCLR: win_len = CW'(1);
      default:  win_len = CW'(SPM_WIN);
    endcase
  end

  assign win_load  = wr_ok & reg_wdata_i[B_EN];
  assign win_clear = spm_take | lpm_take | seq_fin | (wr_ok & ~reg_wdata_i[B_EN]);

  fsp_window #(.CW(CW)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (win_load),
    .len_i    (win_len),
    .clear_i  (win_clear),
    .active_o (win_active),
    .expire_o (win_expire)
  );

  fsp_flash_seq #(.PG_W(PG_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (spm_take),
    .op_wr_i (cmd_q == CMD_WRITE),
    .page_i  (zpage_i),
    .done_i  (fl_done_i),
    .busy_o  (busy),
    .op_wr_o (fl_op_o),
    .page_o  (fl_page_o),
    .fin_o   (seq_fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= 1'b0;
      en_q  <= 1'b0;
      cmd_q <= CMD_NONE;
    end else if (seq_fin) begin
      en_q  <= 1'b0;
      cmd_q <= CMD_NONE;
    end else if (busy) begin
      // writes dropped while halted
    end else if (reg_we_i) begin
      ien_q <= reg_wdata_i[B_IEN];
      en_q  <= reg_wdata_i[B_EN];
      cmd_q <= wr_cmd;
    end else if (spm_take) begin
      // arm held until completion
    end else if (lpm_take || cmd_q == CMD_BCLR || (en_q && win_expire)) begin
      en_q  <= 1'b0;
      cmd_q <= CMD_NONE;
    end
  end

  always_comb begin
    reg_rdata_o         = '0;
    reg_rdata_o[B_IEN]  = ien_q;
    reg_rdata_o[B_BCLR] = (cmd_q == CMD_BCLR);
    reg_rdata_o[B_LCK]  = (cmd_q == CMD_LOCK);
    reg_rdata_o[B_WR]   = (cmd_q == CMD_WRITE);
    reg_rdata_o[B_ERS]  = (cmd_q == CMD_ERASE);
    reg_rdata_o[B_EN]   = en_q;
  end

  assign fl_req_o   = busy;
  assign cpu_halt_o = busy;
  assign buf_clr_o  = (cmd_q == CMD_BCLR);
  assign lock_rd_o  = lpm_take;
  assign fuse_sel_o = lpm_take & zsel_i;
  assign rdy_irq_o  = ien_q & gie_i & ~en_q & ~busy & ~ee_busy_i;

  AST_BUSY_HOLDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> en_q) else $error("busy without arm"); // R7
  AST_START_FROM_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_req_o) |-> $past(en_q)) else $error("start without arm"); // R3
  AST_ARM_HAS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !busy) |-> win_active) else $error("arm outside window"); // R6
  AST_FIN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_fin |=> (!en_q && cmd_q == CMD_NONE)) else $error("no auto clear"); // R6
  AST_LOCK_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_rd_o |=> !en_q) else $error("lock arm kept"); // R8
  AST_BCLR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_clr_o |=> !buf_clr_o) else $error("clear pulse too long"); // R9
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_irq_o |-> !fl_req_o) else $error("irq during op"); // R10
endmodule

// File: tb/flash_selfprog_ctl_bench.sv
`timescale 1ns/1ps
module flash_selfprog_ctl_bench;
  localparam int PG_W = 9;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic spm_strobe_i = 1'b0, lpm_strobe_i = 1'b0;
  logic [PG_W-1:0] zpage_i = '0;
  logic zsel_i = 1'b0, gie_i = 1'b0, ee_busy_i = 1'b0;
  logic fl_req_o, fl_op_o, fl_done_i = 1'b0;
  logic [PG_W-1:0] fl_page_o;
  logic cpu_halt_o, buf_clr_o, lock_rd_o, fuse_sel_o, rdy_irq_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  typedef struct { logic op; logic [PG_W-1:0] page; } op_item_t;
  op_item_t exp_q[$];

  always #2.5 clk = ~clk;

  flash_selfprog_ctl u_flash_selfprog_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .spm_strobe_i(spm_strobe_i), .lpm_strobe_i(lpm_strobe_i),
    .zpage_i(zpage_i), .zsel_i(zsel_i), .gie_i(gie_i), .ee_busy_i(ee_busy_i),
    .fl_req_o(fl_req_o), .fl_op_o(fl_op_o), .fl_page_o(fl_page_o), .fl_done_i(fl_done_i),
    .cpu_halt_o(cpu_halt_o), .buf_clr_o(buf_clr_o), .lock_rd_o(lock_rd_o),
    .fuse_sel_o(fuse_sel_o), .rdy_irq_o(rdy_irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor and flash model
  logic req_prev = 1'b0;
  int   lat_cnt  = 0;
  always @(negedge clk) begin
    if (fl_req_o && !req_prev) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected start", 16'(fl_op_o), 16'hffff);
      end else begin
        op_item_t it;
        it = exp_q.pop_front();
        chk("R3/R4 op kind", 16'(fl_op_o), 16'(it.op));
        chk("R5 page", 16'(fl_page_o), 16'(it.page));
        chk("R7 halt on", 16'(cpu_halt_o), 16'h1);
      end
    end
    if (!fl_req_o && req_prev) chk("R7 halt off", 16'(cpu_halt_o), 16'h0);
    req_prev = fl_req_o;
    if (fl_done_i) fl_done_i = 1'b0;
    else if (fl_req_o) begin
      if (lat_cnt == LAT) begin fl_done_i = 1'b1; lat_cnt = 0; end
      else lat_cnt++;
    end
  end

  task automatic wr(input logic [7:0] d);
    reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spm(input logic [PG_W-1:0] pg, input bit expect_start, input logic op);
    op_item_t it;
    spm_strobe_i = 1'b1; zpage_i = pg;
    if (expect_start) begin it.op = op; it.page = pg; exp_q.push_back(it); end
    @(negedge clk);
    spm_strobe_i = 1'b0;
  endtask

  task automatic wait_done();
    while (fl_req_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 reset readback", 16'(reg_rdata_o), 16'h0);
    chk("R1 reset outputs", 16'({fl_req_o, cpu_halt_o, buf_clr_o, lock_rd_o, rdy_irq_o}), 16'h0);
    rst_ni = 1'b1;
    idle(2);

    // R2 and R12
    wr(8'hE0);
    chk("R2 rsv bits zero, R12 ien only", 16'(reg_rdata_o), 16'h80);
    wr(8'h86);
    chk("R12 command discarded", 16'(reg_rdata_o), 16'h80);
    wr(8'h61);
    chk("R2 enable alone", 16'(reg_rdata_o), 16'h01);
    wr(8'h00);

    // R3: page write at each accepted offset
    for (int d = 0; d < 4; d++) begin
      wr(8'h05);
      chk("R3 armed readback", 16'(reg_rdata_o), 16'h05);
      idle(d);
      spm(9'(9'h0A0 + d), 1'b1, 1'b1);
      chk("R3 request raised", 16'(fl_req_o), 16'h1);
      zpage_i = 9'h1FF;
      wait_done();
      chk("R6 cleared after done", 16'(reg_rdata_o), 16'h0);
    end

    // R4: page erase, with R7 ignored write while busy
    wr(8'h03);
    idle(1);
    spm(9'h155, 1'b1, 1'b0);
    wr(8'h80);
    chk("R7 write ignored while busy", 16'(reg_rdata_o), 16'h03);
    wait_done();
    chk("R7 ien unchanged after op", 16'(reg_rdata_o), 16'h0);

    // R6: window expiry
    wr(8'h05);
    idle(3);
    chk("R6 still armed last cycle", 16'(reg_rdata_o), 16'h05);
    idle(1);
    chk("R6 expired", 16'(reg_rdata_o), 16'h0);
    spm(9'h011, 1'b0, 1'b0);
    chk("R6 late strobe no start", 16'(fl_req_o), 16'h0);

    // R8: lock read
    for (int d = 0; d < 3; d++) begin
      wr(8'h09);
      idle(d);
      lpm_strobe_i = 1'b1; zsel_i = d[0];
      #1;
      chk("R8 redirect", 16'(lock_rd_o), 16'h1);
      chk("R8 fuse select", 16'(fuse_sel_o), 16'(d[0]));
      @(negedge clk);
      lpm_strobe_i = 1'b0;
      chk("R8 arm consumed", 16'(reg_rdata_o), 16'h0);
    end
    wr(8'h09);
    idle(3);
    lpm_strobe_i = 1'b1;
    #1;
    chk("R8 late load not redirected", 16'(lock_rd_o), 16'h0);
    @(negedge clk);
    lpm_strobe_i = 1'b0;

    // R9: buffer clear
    wr(8'h11);
    chk("R9 pulse", 16'(buf_clr_o), 16'h1);
    chk("R9 readback during pulse", 16'(reg_rdata_o), 16'h11);
    idle(1);
    chk("R9 pulse ends", 16'(buf_clr_o), 16'h0);
    chk("R9 cleared", 16'(reg_rdata_o), 16'h0);

    // R11: priority
    wr(8'h0F);
    chk("R11 erase wins", 16'(reg_rdata_o), 16'h03);
    spm(9'h0C3, 1'b1, 1'b0);
    wait_done();
    wr(8'h1D);
    chk("R11 write beats lock", 16'(reg_rdata_o), 16'h05);
    wr(8'h19);
    chk("R11 lock beats clear", 16'(reg_rdata_o), 16'h09);
    chk("R11 no clear pulse", 16'(buf_clr_o), 16'h0);
    wr(8'h00);

    // R10: interrupt
    gie_i = 1'b1;
    wr(8'h80);
    chk("R10 irq on", 16'(rdy_irq_o), 16'h1);
    ee_busy_i = 1'b1; #1;
    chk("R10 eeprom blocks", 16'(rdy_irq_o), 16'h0);
    @(negedge clk);
    ee_busy_i = 1'b0;
    wr(8'h85);
    chk("R10 armed blocks", 16'(rdy_irq_o), 16'h0);
    spm(9'h007, 1'b1, 1'b1);
    chk("R10 op blocks", 16'(rdy_irq_o), 16'h0);
    wait_done();
    chk("R10 irq after op", 16'(rdy_irq_o), 16'h1);
    gie_i = 1'b0; #1;
    chk("R10 gie off", 16'(rdy_irq_o), 16'h0);
    @(negedge clk);

    chk("R3 all expected starts seen", 16'(exp_q.size()), 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    done_flag = 1;
    $finish;
  end
endmodule